// File: doc/BRIEF.md
# Two-Location Host Access Port with Buffer Memory Pointers

This block is the host-facing front end of a network controller. An ISA-style bus sees only two I/O locations: a command-select input picks between the index location and the data location. A write to the index location stores a register number. A data-location cycle then reaches either a small set of byte registers or one of four memory command indexes. Two of these read the receive area of a 16 KB internal RAM and two write its transmit area. One of each pair moves its pointer and the other leaves it where it is.

Memory reads go through a one-entry prefetch buffer. Every read returns what the buffer held and then refills the buffer from the current read pointer. The first read of a burst is therefore a throwaway. Pointer steps follow the bus width (1, 2 or 4 bytes). The transmit write pointer and the receive read pointer each wrap at their own boundary when the wrap-enable mask bit is set. A combinational active-low word-width indication tells the bus that a memory command cycle is 16 or 32 bits wide.

Control has two states. `ST_IDLE` accepts one selected bus strobe. A memory read moves it to `ST_FETCH`, where the RAM output is captured into the prefetch buffer; `ST_FETCH` always returns to `ST_IDLE` on the next clock. Every other access completes within `ST_IDLE`.

Top module: `hostport_ctrl`

## Requirements
- R1: A strobe is accepted only when `aen` is low and `io_addr[9:8]` is 2'b11, `io_addr[7]` is 0, and `io_addr[6:4]` equals `strap_base` (bases 300h..370h). An unselected strobe changes no state and produces no `rdata_vld`.
- R2: With `cmd_sel` low, a write stores `wdata[7:0]` as the index and a read returns the index on `rdata[7:0]`. With `cmd_sel` high, the cycle reaches the register or memory command named by the index. The index resets to 00h.
- R3: Index F0h read returns the prefetch buffer, reloads the buffer from the read pointer, and leaves the read pointer unchanged.
- R4: Index F2h read returns the prefetch buffer, reloads the buffer from the read pointer, then advances the read pointer by one step.
- R5: Index F6h write stores data at the write pointer without moving it. Index F8h stores data and then advances the write pointer by one step.
- R6: `bus_mode` 2'b00 is 8-bit (step 1), 2'b01 is 16-bit (step 2), 2'b10 is 32-bit (step 4), and 2'b11 behaves as 8-bit.
- R7: Memory data is little-endian. The byte at the pointer is on `rdata[7:0]`/`wdata[7:0]` and the following bytes are on the next lanes. Lanes above the bus width read as zero.
- R8: Once reset has been released, and after any write to a pointer register, the prefetch buffer is invalid. The next memory read returns zero.
- R9: The write pointer resets to 0000h. When mask bit 7 is set, an advance that reaches 0C00h wraps it to 0000h; when clear, it continues to 0C00h.
- R10: The read pointer resets to 0C00h. When mask bit 7 is set, an advance past 3FFFh wraps it to 0C00h; when clear, it rolls to 0000h.
- R11: `word_ind_n` is low only while a selected data-location cycle is addressed, the index is F0h, F2h, F6h or F8h, and `bus_mode` is 2'b01 or 2'b10.
- R12: The read pointer is at F4h (bits 7:0) and F5h (bits 13:8 in bits 5:0). The write pointer is at FAh/FBh in the same layout. The mask is at FFh and resets to 00h. Other indexes read 00h and ignore writes.
- R13: `rdata` and a one-cycle `rdata_vld` appear on the clock after an accepted read strobe. The host leaves at least one idle cycle after every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 10 | Bus I/O address |
| aen | input | 1 | Address-enable; high blocks selection |
| cmd_sel | input | 1 | 0 selects the index location, 1 the data location |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 32 | Write data lanes |
| strap_base | input | 3 | Matched against io_addr[6:4] |
| bus_mode | input | 2 | Bus width mode |
| rdata | output | 32 | Read data lanes |
| rdata_vld | output | 1 | Read data valid pulse |
| word_ind_n | output | 1 | Active-low wide memory cycle indication |

## Verification
The checks assume that the host never issues a strobe in the cycle right after another strobe and never raises read and write together. Under that assumption a read strobe always lands in `ST_IDLE`, and an accepted read always yields `rdata_vld` on the next cycle. The bench driver issues every access as one strobe cycle followed by one idle cycle, so it stays within this rule. It also reads memory only at bytes it has written before, or through dummy reads whose result is defined as zero.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_FETCH
    } port_state_t;

    localparam logic [7:0] IDX_RD_KEEP = 8'hF0;
    localparam logic [7:0] IDX_RD_ADV  = 8'hF2;
    localparam logic [7:0] IDX_RPTR_LO = 8'hF4;
    localparam logic [7:0] IDX_RPTR_HI = 8'hF5;
    localparam logic [7:0] IDX_WR_KEEP = 8'hF6;
    localparam logic [7:0] IDX_WR_ADV  = 8'hF8;
    localparam logic [7:0] IDX_WPTR_LO = 8'hFA;
    localparam logic [7:0] IDX_WPTR_HI = 8'hFB;
    localparam logic [7:0] IDX_MASK    = 8'hFF;

    // Pointer step per bus mode; mode 2'b11 falls back to byte access.
    function automatic logic [2:0] step_of(input logic [1:0] mode);
        unique case (mode)
            2'b01:   step_of = 3'd2;
            2'b10:   step_of = 3'd4;
            default: step_of = 3'd1;
        endcase
    endfunction

    // Active byte lanes per bus mode.
    function automatic logic [3:0] lanes_of(input logic [1:0] mode);
        unique case (mode)
            2'b01:   lanes_of = 4'b0011;
            2'b10:   lanes_of = 4'b1111;
            default: lanes_of = 4'b0001;
        endcase
    endfunction

    function automatic logic is_mem_idx(input logic [7:0] idx);
        is_mem_idx = (idx == IDX_RD_KEEP) || (idx == IDX_RD_ADV) ||
                     (idx == IDX_WR_KEEP) || (idx == IDX_WR_ADV);
    endfunction

endpackage

// File: rtl/hostport_decode.sv
module hostport_decode
    import hostport_pkg::*;
(
    input  logic [9:0] io_addr,
    input  logic       aen,
    input  logic [2:0] strap_base,
    input  logic       cmd_sel,
    input  logic [7:0] index_q,
    input  logic [1:0] bus_mode,
    output logic       chip_sel,
    output logic       word_ind_n
);
    logic wide_bus;

    always_comb begin
        chip_sel   = (io_addr[9:8] == 2'b11) && !io_addr[7] && !aen &&
                     (io_addr[6:4] == strap_base);
        wide_bus   = (bus_mode == 2'b01) || (bus_mode == 2'b10);
        word_ind_n = !(chip_sel && cmd_sel && wide_bus && is_mem_idx(index_q));
    end
endmodule

// File: rtl/hostport_ptr.sv
module hostport_ptr #(
    parameter int AW        = 14,
    parameter int RST_VAL   = 0,
    parameter int WRAP_END  = 3072,
    parameter int WRAP_BASE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [2:0]    step,
    input  logic          wrap_en,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [7:0]    ld_byte,
    output logic [AW-1:0] ptr
);
    localparam int HI_W = AW - 8;

    logic [AW:0]   sum;
    logic [AW:0]   folded;
    logic [AW-1:0] nxt;

    always_comb begin
        sum    = {1'b0, ptr} + (AW+1)'(step);
        folded = sum - (AW+1)'(WRAP_END) + (AW+1)'(WRAP_BASE);
        if (wrap_en && (sum >= (AW+1)'(WRAP_END)))
            nxt = folded[AW-1:0];
        else
            nxt = sum[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= AW'(RST_VAL);
        end else if (ld_lo) begin
            ptr[7:0] <= ld_byte;
        end else if (ld_hi) begin
            ptr[AW-1:8] <= ld_byte[HI_W-1:0];
        end else if (adv) begin
            ptr <= nxt;
        end
    end
endmodule

// File: rtl/hostport_ram.sv
module hostport_ram #(
    parameter int MEM_BYTES = 16384,
    parameter int LANES     = 4
) (
    input  logic                          clk,
    input  logic [$clog2(MEM_BYTES)-1:0]  wr_addr,
    input  logic [LANES-1:0]              wr_lane_en,
    input  logic [8*LANES-1:0]            wr_data,
    input  logic                          rd_en,
    input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
    output logic [8*LANES-1:0]            rd_q
);
    localparam int AW    = $clog2(MEM_BYTES);
    localparam int LW    = $clog2(LANES);
    localparam int WORDS = MEM_BYTES / LANES;

    logic [8*LANES-1:0] mem [WORDS];
    logic [AW-1:0]      wa  [LANES];
    logic [AW-1:0]      ra  [LANES];

    // Byte i of an access sits at pointer + i, modulo the RAM size.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            wa[i] = wr_addr + AW'(i);
            ra[i] = rd_addr + AW'(i);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wr_lane_en[i])
                mem[wa[i][AW-1:LW]][8*wa[i][LW-1:0] +: 8] <= wr_data[8*i +: 8];
            if (rd_en)
                rd_q[8*i +: 8] <= mem[ra[i][AW-1:LW]][8*ra[i][LW-1:0] +: 8];
        end
    end
endmodule

// File: rtl/hostport_ctrl.sv
module hostport_ctrl
    import hostport_pkg::*;
#(
    parameter int MEM_BYTES = 16384,
    parameter int TX_BYTES  = 3072
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [9:0]  io_addr,
    input  logic        aen,
    input  logic        cmd_sel,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [31:0] wdata,
    input  logic [2:0]  strap_base,
    input  logic [1:0]  bus_mode,
    output logic [31:0] rdata,
    output logic        rdata_vld,
    output logic        word_ind_n
);
    localparam int AW = $clog2(MEM_BYTES);

    port_state_t   state_q, state_d;
    logic          chip_sel;
    logic [7:0]    index_q;
    logic [7:0]    mask_q;
    logic [31:0]   pbuf_q;
    logic          pbuf_vld_q;
    logic [31:0]   ram_q;
    logic [AW-1:0] rptr, wptr;
    logic [31:0]   lane_mask;
    logic [7:0]    reg_byte;

    logic host_rd, host_wr, idx_rd, idx_wr, dat_rd, dat_wr;
    logic mem_rd, mem_wr, rd_adv, wr_adv;
    logic rp_lo, rp_hi, wp_lo, wp_hi, ptr_ld;

    hostport_decode u_decode (
        .io_addr    (io_addr),
        .aen        (aen),
        .strap_base (strap_base),
        .cmd_sel    (cmd_sel),
        .index_q    (index_q),
        .bus_mode   (bus_mode),
        .chip_sel   (chip_sel),
        .word_ind_n (word_ind_n)
    );

    always_comb begin
        host_rd = rd_stb && chip_sel && (state_q == ST_IDLE);
        host_wr = wr_stb && chip_sel && (state_q == ST_IDLE);
        idx_rd  = host_rd && !cmd_sel;
        idx_wr  = host_wr && !cmd_sel;
        dat_rd  = host_rd && cmd_sel;
        dat_wr  = host_wr && cmd_sel;
        mem_rd  = dat_rd && ((index_q == IDX_RD_KEEP) || (index_q == IDX_RD_ADV));
        rd_adv  = dat_rd && (index_q == IDX_RD_ADV);
        mem_wr  = dat_wr && ((index_q == IDX_WR_KEEP) || (index_q == IDX_WR_ADV));
        wr_adv  = dat_wr && (index_q == IDX_WR_ADV);
        rp_lo   = dat_wr && (index_q == IDX_RPTR_LO);
        rp_hi   = dat_wr && (index_q == IDX_RPTR_HI);
        wp_lo   = dat_wr && (index_q == IDX_WPTR_LO);
        wp_hi   = dat_wr && (index_q == IDX_WPTR_HI);
        ptr_ld  = rp_lo || rp_hi || wp_lo || wp_hi;
    end

    // Receive-side read pointer: wraps back into the receive area.
    hostport_ptr #(
        .AW(AW), .RST_VAL(TX_BYTES), .WRAP_END(MEM_BYTES), .WRAP_BASE(TX_BYTES)
    ) u_rptr (
        .clk(clk), .rst_n(rst_n), .adv(rd_adv), .step(step_of(bus_mode)),
        .wrap_en(mask_q[7]), .ld_lo(rp_lo), .ld_hi(rp_hi),
        .ld_byte(wdata[7:0]), .ptr(rptr)
    );

    // Transmit-side write pointer: wraps to the start of RAM.
    hostport_ptr #(
        .AW(AW), .RST_VAL(0), .WRAP_END(TX_BYTES), .WRAP_BASE(0)
    ) u_wptr (
        .clk(clk), .rst_n(rst_n), .adv(wr_adv), .step(step_of(bus_mode)),
        .wrap_en(mask_q[7]), .ld_lo(wp_lo), .ld_hi(wp_hi),
        .ld_byte(wdata[7:0]), .ptr(wptr)
    );

    hostport_ram #(.MEM_BYTES(MEM_BYTES), .LANES(4)) u_ram (
        .clk        (clk),
        .wr_addr    (wptr),
        .wr_lane_en (mem_wr ? lanes_of(bus_mode) : 4'b0000),
        .wr_data    (wdata),
        .rd_en      (mem_rd),
        .rd_addr    (rptr),
        .rd_q       (ram_q)
    );

    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_lane
            assign lane_mask[8*g +: 8] = {8{lanes_of(bus_mode)[g]}};
        end
    endgenerate

    always_comb begin
        unique case (index_q)
            IDX_RPTR_LO: reg_byte = rptr[7:0];
            IDX_RPTR_HI: reg_byte = 8'(rptr[AW-1:8]);
            IDX_WPTR_LO: reg_byte = wptr[7:0];
            IDX_WPTR_HI: reg_byte = 8'(wptr[AW-1:8]);
            IDX_MASK:    reg_byte = mask_q;
            default:     reg_byte = 8'h00;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (mem_rd) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_IDLE;
        endcase
    end

    // Output and register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q    <= 8'h00;
            mask_q     <= 8'h00;
            pbuf_q     <= 32'h0;
            pbuf_vld_q <= 1'b0;
            rdata      <= 32'h0;
            rdata_vld  <= 1'b0;
        end else begin
            rdata_vld <= host_rd;
            if (idx_wr) index_q <= wdata[7:0];
            if (dat_wr && (index_q == IDX_MASK)) mask_q <= wdata[7:0];
            if (idx_rd)
                rdata <= {24'h0, index_q};
            else if (mem_rd)
                rdata <= pbuf_vld_q ? (pbuf_q & lane_mask) : 32'h0;
            else if (dat_rd)
                rdata <= {24'h0, reg_byte};
            unique case (state_q)
                ST_IDLE: if (ptr_ld) pbuf_vld_q <= 1'b0;
                ST_FETCH: begin
                    pbuf_q     <= ram_q;
                    pbuf_vld_q <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/hostport_ctrl_chk.sv
module hostport_ctrl_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic [9:0]    io_addr,
    input logic          aen,
    input logic [2:0]    strap_base,
    input logic          cmd_sel,
    input logic          rd_stb,
    input logic          wr_stb,
    input logic [1:0]    bus_mode,
    input logic          rdata_vld,
    input logic          word_ind_n,
    input logic [7:0]    index_q,
    input logic [AW-1:0] rptr,
    input logic [AW-1:0] wptr,
    input logic          wrap_en
);
    logic picked;
    assign picked = (io_addr[9:8] == 2'b11) && !io_addr[7] && !aen &&
                    (io_addr[6:4] == strap_base);

    assert_strobe_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |=> !(rd_stb || wr_stb));

    assert_no_dual_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    assert_read_answers_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && picked) |=> rdata_vld);

    assert_unselected_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !picked) |=> !rdata_vld);

    assert_keep_rptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && picked && cmd_sel && index_q == 8'hF0) |=> $stable(rptr));

    assert_keep_wptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && picked && cmd_sel && index_q == 8'hF6) |=> $stable(wptr));

    assert_step_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && picked && cmd_sel && index_q == 8'hF2 && !wrap_en && bus_mode == 2'b10)
        |=> rptr == $past(rptr) + AW'(4));

    assert_word_ind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !word_ind_n |-> (picked && cmd_sel && (bus_mode == 2'b01 || bus_mode == 2'b10)));
endmodule

bind hostport_ctrl hostport_ctrl_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .aen(aen),
    .strap_base(strap_base), .cmd_sel(cmd_sel), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .bus_mode(bus_mode), .rdata_vld(rdata_vld),
    .word_ind_n(word_ind_n), .index_q(index_q), .rptr(rptr), .wptr(wptr),
    .wrap_en(mask_q[7])
);

// File: tb/hostport_ctrl_tb_top.sv
module hostport_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] BASE = 10'h350;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  io_addr = BASE;
    logic        aen = 1'b0;
    logic        cmd_sel = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [2:0]  strap_base = 3'b101;
    logic [1:0]  bus_mode = 2'b00;
    logic [31:0] rdata;
    logic        rdata_vld;
    logic        word_ind_n;

    int tests = 0;
    int fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hostport_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .aen(aen),
        .cmd_sel(cmd_sel), .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata),
        .strap_base(strap_base), .bus_mode(bus_mode), .rdata(rdata),
        .rdata_vld(rdata_vld), .word_ind_n(word_ind_n)
    );

    // Monitor: pops one expected item per returned read.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rdata_vld) begin
                tests++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected read data: actual %h expected none", rdata);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rdata !== e) begin
                        fails++;
                        $display("FAIL %s: actual %h expected %h", t, rdata, e);
                    end
                end
            end
        end
    end

    task automatic bus_wr(input logic [9:0] a, input logic c, input logic [31:0] d);
        @(negedge clk);
        io_addr = a; cmd_sel = c; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; io_addr = BASE; aen = 1'b0;
    endtask

    task automatic bus_rd(input logic c, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        io_addr = BASE; cmd_sel = c; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic set_idx(input logic [7:0] i);
        bus_wr(BASE, 1'b0, {24'h0, i});
    endtask

    task automatic wr_reg(input logic [7:0] i, input logic [31:0] v);
        set_idx(i);
        bus_wr(BASE, 1'b1, v);
    endtask

    task automatic rd_reg(input logic [7:0] i, input logic [7:0] e, input string t);
        set_idx(i);
        bus_rd(1'b1, {24'h0, e}, t);
    endtask

    task automatic set_rptr(input logic [13:0] p);
        wr_reg(8'hF4, {24'h0, p[7:0]});
        wr_reg(8'hF5, {26'h0, p[13:8]});
    endtask

    task automatic set_wptr(input logic [13:0] p);
        wr_reg(8'hFA, {24'h0, p[7:0]});
        wr_reg(8'hFB, {26'h0, p[13:8]});
    endtask

    task automatic chk_ind(input logic e, input string t);
        @(negedge clk);
        tests++;
        if (word_ind_n !== e) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", t, word_ind_n, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R2, R12, R9, R10)
        bus_rd(1'b0, 32'h00, "R2 index resets to 0");
        rd_reg(8'hF4, 8'h00, "R10 rptr low reset");
        rd_reg(8'hF5, 8'h0C, "R10 rptr high reset");
        rd_reg(8'hFA, 8'h00, "R9 wptr low reset");
        rd_reg(8'hFB, 8'h00, "R9 wptr high reset");
        rd_reg(8'hFF, 8'h00, "R12 mask reset");

        // Decode (R1): wrong strap and aen high writes ignored
        set_idx(8'h11);
        bus_wr(10'h340, 1'b0, 32'h22);
        @(negedge clk); aen = 1'b1;
        bus_wr(BASE, 1'b0, 32'h33);
        bus_rd(1'b0, 32'h11, "R1 unselected writes ignored");
        @(negedge clk);
        io_addr = 10'h250; cmd_sel = 1'b0; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; io_addr = BASE;
        tests++;
        if (rdata_vld !== 1'b0) begin
            fails++;
            $display("FAIL R1 unselected read: actual %b expected 0", rdata_vld);
        end
        rd_reg(8'h05, 8'h00, "R12 unused index reads zero");

        // 8-bit writes and reads (R3, R4, R5, R8)
        bus_mode = 2'b00;
        set_idx(8'hF8);
        bus_wr(BASE, 1'b1, 32'h11);
        bus_wr(BASE, 1'b1, 32'h22);
        bus_wr(BASE, 1'b1, 32'h33);
        set_idx(8'hF6);
        bus_wr(BASE, 1'b1, 32'h44);
        rd_reg(8'hFA, 8'h03, "R5 F6 keeps wptr");
        set_idx(8'hF8);
        bus_wr(BASE, 1'b1, 32'h55);
        rd_reg(8'hFA, 8'h04, "R5 F8 advances wptr");
        set_rptr(14'h0000);
        set_idx(8'hF2);
        bus_rd(1'b1, 32'h00, "R8 dummy read after pointer write");
        bus_rd(1'b1, 32'h11, "R4 first byte");
        bus_rd(1'b1, 32'h22, "R4 second byte");
        set_idx(8'hF0);
        bus_rd(1'b1, 32'h33, "R3 keep read returns buffer");
        bus_rd(1'b1, 32'h55, "R3 keep read reloads same spot");
        set_idx(8'hF2);
        bus_rd(1'b1, 32'h55, "R4 advance after keep");
        rd_reg(8'hF4, 8'h04, "R4 rptr advanced");
        rd_reg(8'hF4, 8'h04, "R3 rptr stayed on keep");

        // 16-bit lanes (R6, R7, R8, R11)
        bus_mode = 2'b01;
        set_wptr(14'h0010);
        set_idx(8'hF8);
        bus_wr(BASE, 1'b1, 32'h0000BEEF);
        bus_wr(BASE, 1'b1, 32'h00001234);
        rd_reg(8'hFA, 8'h14, "R6 16-bit step 2");
        set_rptr(14'h0010);
        set_idx(8'hF2);
        bus_rd(1'b1, 32'h0, "R8 stale buffer hidden");
        bus_rd(1'b1, 32'h0000BEEF, "R7 little-endian halfword");
        bus_rd(1'b1, 32'h00001234, "R7 next halfword");
        rd_reg(8'hF4, 8'h16, "R6 rptr 16-bit step");
        set_idx(8'hF2);
        io_addr = BASE; cmd_sel = 1'b1;
        chk_ind(1'b0, "R11 wide memory cycle");
        cmd_sel = 1'b0;
        chk_ind(1'b1, "R11 index location");
        cmd_sel = 1'b1; bus_mode = 2'b00;
        chk_ind(1'b1, "R11 8-bit mode");
        bus_mode = 2'b11;
        chk_ind(1'b1, "R6 mode 3 acts as 8-bit");
        bus_mode = 2'b01; io_addr = 10'h360;
        chk_ind(1'b1, "R11 unselected");
        io_addr = BASE;
        set_idx(8'hF4);
        cmd_sel = 1'b1;
        chk_ind(1'b1, "R11 register index");

        // 32-bit (R6, R7)
        bus_mode = 2'b10;
        set_wptr(14'h0020);
        set_idx(8'hF8);
        bus_wr(BASE, 1'b1, 32'hCAFEF00D);
        rd_reg(8'hFA, 8'h24, "R6 32-bit wptr step 4");
        set_rptr(14'h0020);
        set_idx(8'hF2);
        bus_rd(1'b1, 32'h0, "R8 dummy 32-bit");
        bus_rd(1'b1, 32'hCAFEF00D, "R7 word lanes");
        rd_reg(8'hF4, 8'h28, "R6 32-bit rptr step");

        // Wrap rules (R9, R10, R12)
        bus_mode = 2'b01;
        wr_reg(8'hFF, 32'h80);
        rd_reg(8'hFF, 8'h80, "R12 mask readback");
        set_wptr(14'h0BFE);
        set_idx(8'hF8);
        bus_wr(BASE, 1'b1, 32'h0000A1A2);
        rd_reg(8'hFA, 8'h00, "R9 wptr wraps low");
        rd_reg(8'hFB, 8'h00, "R9 wptr wraps high");
        set_rptr(14'h3FFE);
        set_idx(8'hF2);
        bus_rd(1'b1, 32'h0, "R8 dummy before read wrap");
        rd_reg(8'hF5, 8'h0C, "R10 rptr wraps to receive start");
        rd_reg(8'hF4, 8'h00, "R10 rptr wrap low");
        wr_reg(8'hFF, 32'h00);
        set_wptr(14'h0BFE);
        set_idx(8'hF8);
        bus_wr(BASE, 1'b1, 32'h0000B1B2);
        rd_reg(8'hFB, 8'h0C, "R9 no wrap passes boundary");
        set_rptr(14'h3FFE);
        set_idx(8'hF2);
        bus_rd(1'b1, 32'h0, "R8 dummy before rollover");
        rd_reg(8'hF5, 8'h00, "R10 no wrap rolls to zero");

        repeat (4) @(negedge clk);
        tests++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R13 missing reads: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule